// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between the host write path and the program/erase engine of a flash array. It watches each accepted write cycle (address and data) and tracks the multi-cycle unlock protocol that guards every data-altering operation. A protocol that completes correctly produces a single-cycle start pulse toward the engine. The pulse carries the operation type and the captured address and data. The protocol covers four operations: word program, sector erase, block erase and whole-array erase. Any write that does not fit the expected step abandons the sequence and returns the decoder to its idle read state.

The same protocol engine also switches the part into an identification read mode and back out again. While that mode is active, reads at word offset 0 and 1 return fixed identification words. While the engine reports busy, every write is dropped, so no command of any kind can be started or queued during a program or erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `op_start` is 0, `id_mode` is 0, `op_kind` is 0 and `op_addr` and `op_data` are all zeros.
- R2: Four writes produce a word program request: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then any word at any address. On the clock edge that accepts the fourth write, `op_start` rises for exactly one cycle with `op_kind` = 0 (program), and `op_addr`/`op_data` equal the full fourth-write address and data.
- R3: Six writes produce a whole-array erase: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 10h@5555h. The decoder then pulses `op_start` with `op_kind` = 3. If 10h arrives at any other address in the sixth step, the sequence aborts with no pulse.
- R4: The same five-write erase prefix followed by 30h at any address pulses `op_start` with `op_kind` = 1 (sector erase). `op_addr` holds that full address.
- R5: The same erase prefix followed by 50h at any address pulses `op_start` with `op_kind` = 2 (block erase). `op_addr` holds that full address.
- R6: During command steps, only address bits 14..0 and data bits 7..0 are compared. Higher address bits and data bits 15..8 do not affect recognition.
- R7: A write that does not match the expected step returns the decoder to idle. The remaining steps of the interrupted sequence then start nothing, and a fresh sequence is needed.
- R8: While `busy` is 1, writes are ignored. They cause no pulse, do not change `id_mode` and do not advance or reset the sequence in progress.
- R9: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. While it is set, `id_word` is 00BFh for `rd_addr` = 0, `DEV_ID` for `rd_addr` = 1, and 0 for any other address. With `id_mode` clear, `id_word` is 0.
- R10: A single write of F0h (low byte) at any address, made from the idle state, clears `id_mode`.
- R11: AAh@5555h, 55h@2AAAh, F0h@5555h clears `id_mode`. An incomplete prefix leaves it set.
- R12: Between start pulses, `op_kind`, `op_addr` and `op_data` hold their last captured values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One accepted host write in this cycle |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data word |
| busy | input | 1 | Program/erase engine is running |
| rd_addr | input | ADDR_W | Read address for identification reads |
| op_start | output | 1 | One-cycle request to the engine |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 whole-array erase |
| op_addr | output | ADDR_W | Captured target address |
| op_data | output | 16 | Captured data word |
| id_mode | output | 1 | Identification read mode active |
| id_word | output | 16 | Identification read data |

## Verification
The embedded properties assume that the engine raises `busy` in the cycle after a start pulse, or at least does not issue new writes before then. They also assume that `wr_valid` is a clean single-cycle qualifier per write. The bench drives every write as one cycle of `wr_valid`, changed only on falling clock edges. It raises `busy` only between complete host transactions, or deliberately in the middle of a sequence to exercise the lockout. It never drives `busy` and the final write of a sequence in a way that would make a start pulse coincide with a lockout cycle.

// File: rtl/flash_cmd_pkg.sv
// Package: shared types and the fixed command patterns of the unlock protocol.
// Assumes command steps compare a 15-bit address and an 8-bit data code.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA3,
        SQ_ERA4,
        SQ_ERA5
    } seq_state_t;

    localparam int CMP_AW = 15;
    localparam int N_PAT  = 7;

    localparam int P_AA = 0;
    localparam int P_55 = 1;
    localparam int P_A0 = 2;
    localparam int P_80 = 3;
    localparam int P_90 = 4;
    localparam int P_10 = 5;
    localparam int P_F0 = 6;

    localparam logic [7:0] D_SECT = 8'h30;
    localparam logic [7:0] D_BLK  = 8'h50;
    localparam logic [7:0] D_EXIT = 8'hF0;
    localparam logic [15:0] MFR_ID = 16'h00BF;

    function automatic logic [CMP_AW-1:0] pat_addr(input int idx);
        case (idx)
            P_55:    return 15'h2AAA;
            default: return 15'h5555;
        endcase
    endfunction

    function automatic logic [7:0] pat_data(input int idx);
        case (idx)
            P_AA:    return 8'hAA;
            P_55:    return 8'h55;
            P_A0:    return 8'hA0;
            P_80:    return 8'h80;
            P_90:    return 8'h90;
            P_10:    return 8'h10;
            default: return 8'hF0;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_match.sv
// Module: compares one write against every fixed address/data command pattern.
// Assumes the caller passes only the compared slices (address 14..0, data 7..0).
module flash_cmd_match
    import flash_cmd_pkg::*;
(
    input  logic [CMP_AW-1:0] addr_lo,
    input  logic [7:0]        data_lo,
    output logic [N_PAT-1:0]  hit
);

    // One comparator per pattern, built from the package table.
    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        assign hit[g] = (addr_lo == pat_addr(g)) && (data_lo == pat_data(g));
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: unlock sequence state machine, start pulse, captured operands and
// identification mode flag. Assumes busy is high for the whole engine run and
// that the engine does not need a second request before busy rises.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [N_PAT-1:0]  hit,
    output logic              op_start,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic              id_mode
);

    seq_state_t state_q, state_d;
    logic       take, go, id_set, id_clr;
    op_kind_t   kind_d;
    logic [7:0] dlo;

    assign take = wr_valid && !busy;
    assign dlo  = wr_data[7:0];

    // Next-state decode for one accepted write; mismatch falls back to idle.
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        kind_d  = OP_PROG;
        id_set  = 1'b0;
        id_clr  = 1'b0;
        if (take) begin
            state_d = SQ_IDLE;
            case (state_q)
                SQ_IDLE: begin
                    if (hit[P_AA])        state_d = SQ_UNL1;
                    else if (dlo == D_EXIT) id_clr = 1'b1;
                end
                SQ_UNL1: if (hit[P_55]) state_d = SQ_UNL2;
                SQ_UNL2: begin
                    if (hit[P_A0])      state_d = SQ_PROG;
                    else if (hit[P_80]) state_d = SQ_ERA3;
                    else if (hit[P_90]) id_set = 1'b1;
                    else if (hit[P_F0]) id_clr = 1'b1;
                end
                SQ_PROG: begin
                    go     = 1'b1;
                    kind_d = OP_PROG;
                end
                SQ_ERA3: if (hit[P_AA]) state_d = SQ_ERA4;
                SQ_ERA4: if (hit[P_55]) state_d = SQ_ERA5;
                SQ_ERA5: begin
                    if (hit[P_10]) begin
                        go = 1'b1; kind_d = OP_CHIP;
                    end else if (dlo == D_SECT) begin
                        go = 1'b1; kind_d = OP_SECT;
                    end else if (dlo == D_BLK) begin
                        go = 1'b1; kind_d = OP_BLK;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Start pulse and operand capture, held until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_kind  <= OP_PROG;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= go;
            if (go) begin
                op_kind <= kind_d;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    // Identification mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n)      id_mode <= 1'b0;
        else if (id_set) id_mode <= 1'b1;
        else if (id_clr) id_mode <= 1'b0;
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    assert_busy_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !op_start);

    assert_operand_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |-> ($stable(op_addr) && $stable(op_data) && $stable(op_kind)));

    assert_idmode_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid || busy) |=> $stable(id_mode));

endmodule

// File: rtl/flash_id_reply.sv
// Module: identification read data. Assumes reads are combinational on rd_addr
// and that only word offsets 0 and 1 carry identification words.
module flash_id_reply
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 18,
    parameter logic [15:0] DEV_ID = 16'h2791
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       id_word
);

    // Select the identification word for the addressed offset.
    always_comb begin
        id_word = '0;
        if (id_mode && (rd_addr[ADDR_W-1:1] == '0))
            id_word = rd_addr[0] ? DEV_ID : MFR_ID;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: top of the unlock command decoder. Wires the pattern matcher, the
// sequence machine and the identification reply. Assumes ADDR_W >= 16.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W = 18,
    parameter logic [15:0] DEV_ID = 16'h2791
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic              id_mode,
    output logic [15:0]       id_word
);

    logic [N_PAT-1:0] hit;
    op_kind_t         kind;

    flash_cmd_match u_match (
        .addr_lo (wr_addr[CMP_AW-1:0]),
        .data_lo (wr_data[7:0]),
        .hit     (hit)
    );

    flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .busy     (busy),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit      (hit),
        .op_start (op_start),
        .op_kind  (kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .id_mode  (id_mode)
    );

    flash_id_reply #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_word (id_word)
    );

    assign op_kind = kind;

endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

    localparam int          AW  = 18;
    localparam logic [15:0] DID = 16'h2791;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          op_start;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic          id_mode;
    logic [15:0]   id_word;

    int checks = 0;
    int errors = 0;
    int starts = 0;

    logic [1:0]    q_kind[$];
    logic [AW-1:0] q_addr[$];
    logic [15:0]   q_data[$];
    string         q_tag[$];

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DEV_ID(DID)) u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .id_mode(id_mode), .id_word(id_word)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_op(input logic [1:0] k, input logic [AW-1:0] a,
                             input logic [15:0] d, input string tag);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic unlock(input logic [AW-1:0] hi);
        wr(hi | 18'h05555, 16'h00AA);
        wr(hi | 18'h02AAA, 16'h0055);
    endtask

    // Monitor: pops the scoreboard on every start pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && op_start) begin
                starts++;
                if (q_kind.size() == 0) begin
                    check(1'b0, "R7 unexpected start", {op_kind, op_addr}, 0);
                end else begin
                    logic [1:0] ek; logic [AW-1:0] ea; logic [15:0] ed; string et;
                    ek = q_kind.pop_front(); ea = q_addr.pop_front();
                    ed = q_data.pop_front(); et = q_tag.pop_front();
                    check(op_kind == ek && op_addr == ea && op_data == ed, et,
                          {op_kind, op_addr, op_data}, {ek, ea, ed});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(op_start == 0 && id_mode == 0, "R1 reset flags", {op_start, id_mode}, 0);
        check(op_addr == 0 && op_data == 0 && op_kind == 0, "R1 reset operands",
              {op_kind, op_addr, op_data}, 0);
        check(id_word == 0, "R9 id_word zero outside id mode", id_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 word program
        unlock(0);
        wr(18'h05555, 16'h00A0);
        expect_op(2'd0, 18'h2ABCD, 16'hBEEF, "R2 program");
        wr(18'h2ABCD, 16'hBEEF);
        repeat (3) @(negedge clk);
        // R12 operands held
        check(op_addr == 18'h2ABCD && op_data == 16'hBEEF, "R12 operands held",
              {op_addr, op_data}, {18'h2ABCD, 16'hBEEF});

        // R4 + R6 sector erase with upper bits set in command cycles
        unlock(18'h38000);
        wr(18'h3D555, 16'hC380);
        wr(18'h2D555, 16'h11AA);
        wr(18'h1AAAA, 16'hEE55);
        expect_op(2'd1, 18'h1F800, 16'h7730, "R4 R6 sector erase");
        wr(18'h1F800, 16'h7730);

        // R5 block erase
        unlock(0);
        wr(18'h05555, 16'h0080);
        unlock(0);
        expect_op(2'd2, 18'h28000, 16'h0050, "R5 block erase");
        wr(18'h28000, 16'h0050);

        // R3 whole-array erase
        unlock(0);
        wr(18'h05555, 16'h0080);
        unlock(0);
        expect_op(2'd3, 18'h05555, 16'h0010, "R3 chip erase");
        wr(18'h05555, 16'h0010);

        // R3 10h at wrong address aborts
        s0 = starts;
        unlock(0);
        wr(18'h05555, 16'h0080);
        unlock(0);
        wr(18'h01234, 16'h0010);
        repeat (2) @(negedge clk);
        check(starts == s0, "R3 misplaced 10h no start", starts, s0);

        // R7 mismatch mid-sequence, then the rest of the sequence
        s0 = starts;
        unlock(0);
        wr(18'h05555, 16'h0012);
        wr(18'h05555, 16'h00A0);
        wr(18'h00100, 16'h4321);
        repeat (2) @(negedge clk);
        check(starts == s0, "R7 abort then tail", starts, s0);
        unlock(0);
        wr(18'h04444, 16'h0055);
        wr(18'h05555, 16'h00A0);
        wr(18'h00200, 16'h1111);
        repeat (2) @(negedge clk);
        check(starts == s0, "R7 wrong address abort", starts, s0);
        unlock(0);
        wr(18'h05555, 16'h00A0);
        expect_op(2'd0, 18'h00300, 16'h5A5A, "R7 recovery program");
        wr(18'h00300, 16'h5A5A);

        // R8 full program while busy is ignored
        @(negedge clk); busy = 1'b1;
        s0 = starts;
        unlock(0);
        wr(18'h05555, 16'h00A0);
        wr(18'h00400, 16'h9999);
        unlock(0);
        wr(18'h05555, 16'h0090);
        repeat (2) @(negedge clk);
        check(starts == s0, "R8 no start while busy", starts, s0);
        check(id_mode == 0, "R8 no id entry while busy", id_mode, 0);
        // R8 sequence state held across busy
        busy = 1'b0;
        unlock(0);
        @(negedge clk); busy = 1'b1;
        wr(18'h05555, 16'h0080);
        wr(18'h00000, 16'h0033);
        @(negedge clk); busy = 1'b0;
        wr(18'h05555, 16'h00A0);
        expect_op(2'd0, 18'h00500, 16'h0F0F, "R8 sequence held across busy");
        wr(18'h00500, 16'h0F0F);

        // R9 identification mode
        unlock(0);
        wr(18'h05555, 16'h0090);
        check(id_mode == 1, "R9 id entry", id_mode, 1);
        rd_addr = 18'h0; #1;
        check(id_word == 16'h00BF, "R9 offset0", id_word, 16'h00BF);
        rd_addr = 18'h1; #1;
        check(id_word == DID, "R9 offset1", id_word, DID);
        rd_addr = 18'h2; #1;
        check(id_word == 0, "R9 other offset", id_word, 0);
        rd_addr = 18'h0;

        // R10 single exit write
        wr(18'h01234, 16'h00F0);
        check(id_mode == 0, "R10 single exit", id_mode, 0);
        check(id_word == 0, "R10 id_word after exit", id_word, 0);

        // R11 three-cycle exit, partial prefix keeps mode
        unlock(0);
        wr(18'h05555, 16'h0090);
        unlock(0);
        check(id_mode == 1, "R11 prefix keeps id mode", id_mode, 1);
        wr(18'h05555, 16'h00F0);
        check(id_mode == 0, "R11 three-cycle exit", id_mode, 0);

        repeat (3) @(negedge clk);
        check(q_kind.size() == 0, "R2 all expected starts seen", q_kind.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule